// File: doc/BRIEF.md
# Reference Switch Phase Build-Out

This block sits between a reference selector and a digital PLL. When the selection moves between the primary and the secondary reference, the two sources usually differ in phase. Passed straight through, that difference would reach the PLL as a phase step. The block hides the step and emits a virtual reference edge stream that stays continuous in phase. All times are counted in ticks of a fast sampling clock.

The block has two states, Normal and Holdover.

- **Normal:** the virtual reference is the selected reference edge, delayed by a programmable value.
- **Holdover:** a selection change starts this state. The virtual edges are then generated from the last reference period measured in Normal. At the same time the block measures where the new source lies relative to the PLL feedback edges.

When holdover ends, the measured offset becomes the new delay, and the delayed new source lines up with the old phase. The delay persists across switches. Only a sufficiently long active-low clear pulse removes it, which realigns the output to the present input.

Top module: `ref_switch_buildout`

## Requirements
- R1: A change of `sel_sec_i` (0 = primary, 1 = secondary) raises `hold_o` one clock after the edge that samples the change.
- R2: While `hold_o` is high, `vref_o` pulses continue at the stored period, counted from the last `vref_o` pulse, and are not taken from either reference input.
- R3: A further change of `sel_sec_i` during holdover keeps `hold_o` high and restarts the measurement, so the final delay reflects only the source selected last.
- R4: In Normal, a selected reference edge sampled at cycle t produces a `vref_o` pulse visible in cycle t+1+D, where D is `delay_o`.
- R5: On leaving holdover, `delay_o` becomes (f - t - 1) mod PERIOD. Here t is the first new-source edge sampled after the switch, and f is the first later cycle with `fb_i` sampled high. The new-source pulses then land on the feedback phase.
- R6: A switch does not reset `delay_o`: it keeps its old value until the new measurement is loaded, and each new value builds on the phase already carried.
- R7: `clr_ni` sampled low for CLR_MIN consecutive clocks sets `delay_o` to 0 in the next cycle. The output then follows the selected reference with latency 1.
- R8: A low pulse on `clr_ni` shorter than CLR_MIN clocks leaves `delay_o` unchanged.
- R9: Holdover ends only after HOLD_PERIODS holdover pulses and a completed measurement. `hold_o` is still high one PERIOD after the switch.
- R10: The holdover pulse spacing is the last reference edge-to-edge interval measured in Normal. Out of reset this spacing is PERIOD.
- R11: During and right after reset, `hold_o`, `vref_o` and `delay_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, one tick |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_pri_i | input | 1 | Primary reference edge strobe |
| ref_sec_i | input | 1 | Secondary reference edge strobe |
| sel_sec_i | input | 1 | Source select, 1 = secondary |
| fb_i | input | 1 | PLL feedback edge strobe |
| clr_ni | input | 1 | Delay clear, active low, filtered |
| vref_o | output | 1 | Virtual reference edge strobe |
| delay_o | output | $clog2(PERIOD) | Accumulated delay in ticks |
| hold_o | output | 1 | 1 in holdover, 0 in Normal |

## Verification
Each input is driven on the falling edge and counted against the rising edge that samples it.

- **Holdover flag:** `hold_o` is read at the next falling edge after a select change.
- **Cleared delay:** `delay_o` is read at the falling edge right after the CLR_MIN-th low sample.
- **Virtual pulses:** a pulse is expected one plus the delay cycles after the sampled reference edge. The bench therefore checks every pulse's phase within the period against (reference phase + 1 + delay) mod PERIOD.
- **Settling:** results that need a full holdover are read three periods after the switch, which bounds the worst-case measurement and holdover length. After a clear, one extra period passes before phase checks, so a countdown already in flight cannot land in the window.

// File: rtl/bo_pkg.sv
`timescale 1ns/1ps
package bo_pkg;
  typedef enum logic {
    ST_NORM = 1'b0,
    ST_HOLD = 1'b1
  } bo_state_e;
endpackage

// File: rtl/bo_clr_filter.sv
`timescale 1ns/1ps
module bo_clr_filter #(
  parameter int CLR_MIN = 75
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_ni,
  output logic fire_o
);
  localparam int CW = $clog2(CLR_MIN + 1);
  localparam logic [CW-1:0] LIM = CW'(CLR_MIN);
  localparam logic [CW-1:0] LAST = CW'(CLR_MIN - 1);

  logic [CW-1:0] cnt_q;

  // one pulse per qualifying low period
  assign fire_o = !clr_ni && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_ni)      cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + CW'(1);
  end

  AST_CLR_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o); // R8
endmodule

// File: rtl/bo_period_meter.sv
`timescale 1ns/1ps
module bo_period_meter #(
  parameter int PERIOD = 122,
  parameter int PW     = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          edge_i,
  input  logic          en_i,
  output logic [PW-1:0] period_o
);
  localparam logic [PW-1:0] CMAX = PW'(2 * PERIOD);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      period_o <= PW'(PERIOD);
    end else begin
      if (edge_i) cnt_q <= PW'(1);
      else if (cnt_q != CMAX) cnt_q <= cnt_q + PW'(1);
      // keep only plausible intervals
      if (edge_i && en_i && cnt_q != '0 && cnt_q != CMAX) period_o <= cnt_q;
    end
  end

  AST_PERIOD_NZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_o != '0); // R10
endmodule

// File: rtl/bo_delay_line.sv
`timescale 1ns/1ps
module bo_delay_line #(
  parameter int DW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          flush_i,
  input  logic [DW-1:0] delay_i,
  output logic          fire_o
);
  logic          armed_q;
  logic [DW-1:0] cnt_q;

  assign fire_o = (start_i && delay_i == '0) || (armed_q && cnt_q == DW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (flush_i) begin
      armed_q <= 1'b0;
    end else if (start_i && delay_i != '0) begin
      armed_q <= 1'b1;
      cnt_q   <= delay_i;
    end else if (armed_q) begin
      if (cnt_q == DW'(1)) armed_q <= 1'b0;
      cnt_q <= cnt_q - DW'(1);
    end
  end

  AST_ARMED_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> cnt_q != '0); // R4
endmodule

// File: rtl/ref_switch_buildout.sv
`timescale 1ns/1ps
module ref_switch_buildout #(
  parameter int PERIOD       = 122,
  parameter int CLR_MIN      = 75,
  parameter int HOLD_PERIODS = 2,
  localparam int DW = $clog2(PERIOD)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ref_pri_i,
  input  logic          ref_sec_i,
  input  logic          sel_sec_i,
  input  logic          fb_i,
  input  logic          clr_ni,
  output logic          vref_o,
  output logic [DW-1:0] delay_o,
  output logic          hold_o
);
  import bo_pkg::*;

  localparam int PW = $clog2(2 * PERIOD + 1);
  localparam int HW = $clog2(HOLD_PERIODS + 1);
  localparam logic [PW-1:0] PER  = PW'(PERIOD);
  localparam logic [PW-1:0] CMAX = PW'(2 * PERIOD);
  localparam logic [HW-1:0] HN   = HW'(HOLD_PERIODS);

  bo_state_e     state_q;
  logic          sel_q, vref_q;
  logic [DW-1:0] delay_q, cap_q;
  logic [PW-1:0] hg_cnt_q, ph_cnt_q, last_per;
  logic [HW-1:0] hedges_q;
  logic          meas_q, cap_vld_q;

  logic ref_sel, sw, hold, dl_start, dl_fire, hg_fire, clr_fire, done;
  logic [PW-1:0] red1;
  logic [DW-1:0] cap_d;

  assign ref_sel  = sel_sec_i ? ref_sec_i : ref_pri_i;
  assign sw       = sel_sec_i != sel_q;
  assign hold     = state_q == ST_HOLD;
  assign dl_start = ref_sel && !hold && !sw;
  assign hg_fire  = hold && (hg_cnt_q == last_per - PW'(1));
  assign done     = hold && !sw && cap_vld_q && (hedges_q == HN);
  // offset modulo one period, clamped
  assign red1     = (ph_cnt_q >= PER) ? ph_cnt_q - PER : ph_cnt_q;
  assign cap_d    = (red1 >= PER) ? DW'(PERIOD - 1) : DW'(red1);

  bo_clr_filter #(.CLR_MIN(CLR_MIN)) u_clr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(clr_ni), .fire_o(clr_fire));

  bo_period_meter #(.PERIOD(PERIOD), .PW(PW)) u_per (
    .clk_i(clk_i), .rst_ni(rst_ni), .edge_i(ref_sel), .en_i(!hold),
    .period_o(last_per));

  bo_delay_line #(.DW(DW)) u_dl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(dl_start), .flush_i(sw),
    .delay_i(delay_q), .fire_o(dl_fire));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= 1'b0;
      vref_q   <= 1'b0;
      hg_cnt_q <= '0;
    end else begin
      sel_q  <= sel_sec_i;
      vref_q <= hold ? hg_fire : dl_fire;
      if (vref_q) hg_cnt_q <= PW'(1);
      else if (hg_cnt_q != CMAX) hg_cnt_q <= hg_cnt_q + PW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_NORM;
      hedges_q  <= '0;
      meas_q    <= 1'b0;
      cap_vld_q <= 1'b0;
      ph_cnt_q  <= '0;
      cap_q     <= '0;
    end else if (sw) begin
      state_q   <= ST_HOLD;
      hedges_q  <= '0;
      meas_q    <= 1'b0;
      cap_vld_q <= 1'b0;
    end else if (hold) begin
      if (hg_fire && hedges_q != HN) hedges_q <= hedges_q + HW'(1);
      if (!cap_vld_q) begin
        if (meas_q) begin
          if (ph_cnt_q != CMAX) ph_cnt_q <= ph_cnt_q + PW'(1);
          if (fb_i) begin
            cap_vld_q <= 1'b1;
            cap_q     <= cap_d;
            meas_q    <= 1'b0;
          end
        end else if (ref_sel) begin
          meas_q   <= 1'b1;
          ph_cnt_q <= '0;
        end
      end
      if (done) state_q <= ST_NORM;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       delay_q <= '0;
    else if (clr_fire) delay_q <= '0;
    else if (done)     delay_q <= cap_q;
  end

  assign vref_o  = vref_q;
  assign delay_o = delay_q;
  assign hold_o  = hold;

  AST_SWITCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw |=> hold_o); // R1
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_fire |=> delay_o == '0); // R7
  AST_DELAY_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    PW'(delay_o) < PER); // R5
  AST_HOLD_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> $past(cap_vld_q)); // R9
endmodule

// File: tb/tb_ref_switch_buildout.sv
`timescale 1ns/1ps
module tb_ref_switch_buildout;
  localparam int P  = 122;
  localparam int CM = 75;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_pri = 1'b0, ref_sec = 1'b0, sel = 1'b0, fb = 1'b0, clr_n = 1'b1;
  logic vref;
  logic [6:0] dly;
  logic hold;

  int cyc = 0;
  int pa = 10, pb = 50, pf = 11;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  ref_switch_buildout dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_pri_i(ref_pri), .ref_sec_i(ref_sec),
    .sel_sec_i(sel), .fb_i(fb), .clr_ni(clr_n),
    .vref_o(vref), .delay_o(dly), .hold_o(hold));

  initial forever begin
    @(negedge clk);
    ref_pri = (cyc % P) == pa;
    ref_sec = (cyc % P) == pb;
    fb      = (cyc % P) == pf;
  end

  function automatic int exp_dly(int f, int t);
    return ((f - t - 1) % P + 2 * P) % P;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // watch n cycles: every vref pulse must sit at phase ph, at least mn of them
  task automatic watch(int n, int ph, int mn, string req);
    int cnt = 0, wrong = 0, wph = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (vref) begin
        cnt++;
        if ((cyc % P) != ph) begin wrong++; wph = cyc % P; end
      end
    end
    check(wrong == 0, req, wph, ph);
    check(cnt >= mn, req, cnt, mn);
  endtask

  task automatic wait_phase(int ph);
    @(negedge clk);
    while ((cyc % P) != ph) @(negedge clk);
  endtask

  task automatic switch_to(bit s);
    @(negedge clk);
    sel = s;
    @(negedge clk);
    check(hold == 1'b1, "R1 hold after switch", int'(hold), 1);
  endtask

  task automatic clr_pulse(int n);
    @(negedge clk);
    clr_n = 1'b0;
    repeat (n) @(negedge clk);
    clr_n = 1'b1;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(hold == 1'b0 && vref == 1'b0, "R11 outputs in reset", int'(hold) + int'(vref), 0);
    check(dly == 7'd0, "R11 delay in reset", int'(dly), 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(hold == 1'b0 && dly == 7'd0, "R11 after reset", int'(hold) + int'(dly), 0);
    repeat (2 * P) @(negedge clk);
  endtask

  task automatic t_normal;
    watch(3 * P, (pa + 1) % P, 3, "R4 normal latency");
    check(dly == 7'd0, "R4 delay zero", int'(dly), 0);
  endtask

  task automatic t_switch_sec;
    wait_phase((pf + 5) % P);
    switch_to(1'b1);
    check(dly == 7'd0, "R6 delay kept on switch", int'(dly), 0);
    watch(P - 3, pf, 1, "R2 R10 holdover pulses");
    check(hold == 1'b1, "R9 hold after one period", int'(hold), 1);
    repeat (2 * P) @(negedge clk);
    check(hold == 1'b0, "R9 hold ended", int'(hold), 0);
    check(int'(dly) == exp_dly(pf, pb), "R5 measured delay", int'(dly), exp_dly(pf, pb));
    watch(3 * P, pf, 3, "R5 phase continuity");
  endtask

  task automatic t_switch_back;
    int prev;
    prev = int'(dly);
    pa = 100;
    wait_phase((pf + 5) % P);
    switch_to(1'b0);
    check(int'(dly) == prev, "R6 delay kept on second switch", int'(dly), prev);
    repeat (3 * P) @(negedge clk);
    check(int'(dly) == exp_dly(pf, pa), "R6 accumulated delay", int'(dly), exp_dly(pf, pa));
    watch(2 * P, pf, 2, "R6 phase after second switch");
  endtask

  task automatic t_clear;
    int prev;
    prev = int'(dly);
    clr_pulse(CM - 1);
    check(int'(dly) == prev, "R8 short clear ignored", int'(dly), prev);
    repeat (5) @(negedge clk);
    check(int'(dly) == prev, "R8 short clear later", int'(dly), prev);
    clr_pulse(CM);
    check(dly == 7'd0, "R7 clear zeroes delay", int'(dly), 0);
    repeat (P + 5) @(negedge clk);
    watch(2 * P, (pa + 1) % P, 2, "R7 realigned to input");
    pf = (pa + 1) % P;
  endtask

  task automatic t_restart;
    wait_phase((pf + 5) % P);
    switch_to(1'b1);
    repeat (20) @(negedge clk);
    switch_to(1'b0);
    check(hold == 1'b1, "R3 still holding", int'(hold), 1);
    repeat (20) @(negedge clk);
    switch_to(1'b1);
    repeat (P - 2) @(negedge clk);
    check(hold == 1'b1, "R3 restarted holdover", int'(hold), 1);
    repeat (2 * P + 2) @(negedge clk);
    check(int'(dly) == exp_dly(pf, pb), "R3 delay from last source", int'(dly), exp_dly(pf, pb));
    watch(2 * P, pf, 2, "R3 phase after restart");
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_normal();
    t_switch_sec();
    t_switch_back();
    t_clear();
    t_restart();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule